// File: doc/BRIEF.md
# Bridge System Error Reporter

This block drives the active-low system error strobe on the primary side of a two-port bus bridge. It also keeps three sticky status flags that software clears by writing ones. Three kinds of event can cause the strobe:

- a data parity error on a posted write, reported by the bus that was the write's target;
- a target abort met while a posted write completes;
- a system error signalled by the secondary side, which can be forwarded.

Every cause is gated by one master enable.

The surrounding bridge presents one transaction descriptor per cycle. The descriptor gives the type, the direction, and whether the bridge itself caught the parity error as target. Alongside it come per-bus parity-error strobes, the enable bits and the secondary system error pin. The secondary pin is asynchronous. It passes through a synchronizer and an edge detector, so a level held for a long time counts as a single event. The strobe is registered and goes low in the cycle after the cycle that held the triggering inputs.

Top module: `bridge_serr_reporter`

## Requirements
- R1: `serr_n_o` is low only in a cycle that follows a cycle in which `cmd_serr_en` was 1. With `cmd_serr_en` at 0, no trigger produces a low.
- R2: In every cycle where `serr_n_o` is low, `sts_sig_serr` is 1. The flag is set on the same clock edge that drives the strobe low.
- R3: A falling edge on `sec_serr_n`, after the synchronizer, drives `serr_n_o` low for one clock, provided `bctl_serr_fwd_en` and `cmd_serr_en` are both 1. A low level held for many cycles yields exactly one pulse.
- R4: Every synchronized falling edge of `sec_serr_n` sets `sts_rcv_serr`, whatever the enable bits are.
- R5: A posted write (`txn_type`=01) triggers only when the parity strobe was seen on its target bus and not on its initiator bus. With `txn_dir`=0 (downstream) the target is secondary (`sec_perr_seen`). With `txn_dir`=1 (upstream) the target is primary (`pri_perr_seen`).
- R6: A posted write with `txn_self_detect`=1 never triggers.
- R7: A posted write triggers only if both `cmd_perr_resp` and `bctl_perr_resp` are 1.
- R8: Reads (`txn_type`=00) and delayed writes (`txn_type`=10) never trigger, whatever the direction, bus strobes and response enables.
- R9: `pw_tabort`=1 triggers the strobe, subject to `cmd_serr_en` only.
- R10: For each cycle that holds one or more triggers, `serr_n_o` is low for exactly the one following cycle. Simultaneous triggers yield a single one-clock low.
- R11: The flags are sticky. A cycle with `sts_clr_wr`=1 clears each flag whose bit in `sts_clr_data` is 1 (bit0 = `sts_sig_serr`, bit1 = `sts_rcv_serr`, bit2 = `sts_pw_perr`). A set in the same cycle wins over the clear. Zero bits have no effect.
- R12: `sts_pw_perr` is set by every posted write that meets R5 to R7, even when `cmd_serr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_serr_en | input | 1 | Master system error enable |
| cmd_perr_resp | input | 1 | Primary parity response enable |
| bctl_perr_resp | input | 1 | Secondary parity response enable |
| bctl_serr_fwd_en | input | 1 | Secondary system error forwarding enable |
| pri_perr_seen | input | 1 | Parity error strobe seen on primary bus |
| sec_perr_seen | input | 1 | Parity error strobe seen on secondary bus |
| txn_valid | input | 1 | Descriptor valid this cycle |
| txn_type | input | 2 | 00 read, 01 posted write, 10 delayed write |
| txn_dir | input | 1 | 0 downstream, 1 upstream |
| txn_self_detect | input | 1 | Bridge flagged the parity error itself as target |
| sec_serr_n | input | 1 | Asynchronous secondary system error, active low |
| pw_tabort | input | 1 | Target abort on a posted write |
| sts_clr_wr | input | 1 | Status write strobe |
| sts_clr_data | input | 3 | Write-one-to-clear mask |
| serr_n_o | output | 1 | Primary system error strobe, active low |
| sts_sig_serr | output | 1 | Signaled system error flag |
| sts_rcv_serr | output | 1 | Received system error flag |
| sts_pw_perr | output | 1 | Qualifying posted-write parity error flag |

## Verification
The assertions watch every cycle for the following:
- a strobe without the master enable;
- a strobe without the signaled flag;
- a strobe that follows only reads, delayed writes or self-detected errors;
- a signaled flag that drops without a matching clear.

Only the bench scenarios can show the rest:
- the full bus-and-direction qualification table, including the case where both buses saw the error;
- one pulse for a long secondary level;
- the merging of simultaneous triggers;
- set winning over clear and per-bit clearing.

// File: rtl/bserr_pkg.sv
package bserr_pkg;
  typedef enum logic [1:0] {
    TXN_READ    = 2'b00,
    TXN_POSTED  = 2'b01,
    TXN_DELAYED = 2'b10,
    TXN_RSVD    = 2'b11
  } txn_kind_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } txn_dir_e;

  localparam int unsigned FLAG_SIG  = 0;
  localparam int unsigned FLAG_RCV  = 1;
  localparam int unsigned FLAG_PW   = 2;
  localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/bserr_sync_edge.sv
module bserr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic assert_pulse
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], ~async_n};
      prev  <= chain[LAST];
    end
  end

  assign assert_pulse = chain[LAST] & ~prev;
endmodule

// File: rtl/bserr_pw_qual.sv
module bserr_pw_qual
  import bserr_pkg::*;
(
  input  logic       txn_valid,
  input  logic [1:0] txn_type,
  input  logic       txn_dir,
  input  logic       txn_self_detect,
  input  logic       pri_perr_seen,
  input  logic       sec_perr_seen,
  input  logic       cmd_perr_resp,
  input  logic       bctl_perr_resp,
  output logic       pw_hit
);
  txn_kind_e kind;
  txn_dir_e  dir;
  logic      target_seen;
  logic      initiator_seen;
  logic      responses_on;

  always_comb begin
    kind = txn_kind_e'(txn_type);
    dir  = txn_dir_e'(txn_dir);
    if (dir == DIR_DOWN) begin
      target_seen    = sec_perr_seen;
      initiator_seen = pri_perr_seen;
    end else begin
      target_seen    = pri_perr_seen;
      initiator_seen = sec_perr_seen;
    end
    responses_on = cmd_perr_resp & bctl_perr_resp;
    pw_hit = txn_valid && (kind == TXN_POSTED) && !txn_self_detect &&
             responses_on && target_seen && !initiator_seen;
  end
endmodule

// File: rtl/bserr_sticky.sv
module bserr_sticky #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_wr,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] flags_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)                    q <= 1'b0;
      else if (set_i[b])          q <= 1'b1;
      else if (clr_wr && clr_mask[b]) q <= 1'b0;
    end
    assign flags_o[b] = q;
  end
endmodule

// File: rtl/bridge_serr_reporter.sv
module bridge_serr_reporter
  import bserr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_serr_en,
  input  logic       cmd_perr_resp,
  input  logic       bctl_perr_resp,
  input  logic       bctl_serr_fwd_en,
  input  logic       pri_perr_seen,
  input  logic       sec_perr_seen,
  input  logic       txn_valid,
  input  logic [1:0] txn_type,
  input  logic       txn_dir,
  input  logic       txn_self_detect,
  input  logic       sec_serr_n,
  input  logic       pw_tabort,
  input  logic       sts_clr_wr,
  input  logic [2:0] sts_clr_data,
  output logic       serr_n_o,
  output logic       sts_sig_serr,
  output logic       sts_rcv_serr,
  output logic       sts_pw_perr
);
  logic                 sec_edge;
  logic                 pw_hit;
  logic                 fire;
  logic                 serr_q;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flags;

  bserr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst          (rst),
    .async_n      (sec_serr_n),
    .assert_pulse (sec_edge)
  );

  bserr_pw_qual u_qual (
    .txn_valid       (txn_valid),
    .txn_type        (txn_type),
    .txn_dir         (txn_dir),
    .txn_self_detect (txn_self_detect),
    .pri_perr_seen   (pri_perr_seen),
    .sec_perr_seen   (sec_perr_seen),
    .cmd_perr_resp   (cmd_perr_resp),
    .bctl_perr_resp  (bctl_perr_resp),
    .pw_hit          (pw_hit)
  );

  always_comb begin
    fire = cmd_serr_en & (pw_hit | pw_tabort | (bctl_serr_fwd_en & sec_edge));
    flag_set           = '0;
    flag_set[FLAG_SIG] = fire;
    flag_set[FLAG_RCV] = sec_edge;
    flag_set[FLAG_PW]  = pw_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) serr_q <= 1'b0;
    else     serr_q <= fire;
  end

  bserr_sticky #(.WIDTH(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_i    (flag_set),
    .clr_wr   (sts_clr_wr),
    .clr_mask (sts_clr_data),
    .flags_o  (flags)
  );

  assign serr_n_o     = ~serr_q;
  assign sts_sig_serr = flags[FLAG_SIG];
  assign sts_rcv_serr = flags[FLAG_RCV];
  assign sts_pw_perr  = flags[FLAG_PW];
endmodule

// File: rtl/bserr_checker.sv
module bserr_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_serr_en,
  input logic       bctl_serr_fwd_en,
  input logic       txn_valid,
  input logic [1:0] txn_type,
  input logic       txn_self_detect,
  input logic       pw_tabort,
  input logic       sts_clr_wr,
  input logic [2:0] sts_clr_data,
  input logic       serr_n_o,
  input logic       sts_sig_serr
);
  AST_SERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> $past(cmd_serr_en)); // R1

  AST_SERR_SETS_SIGNALED: assert property (@(posedge clk) disable iff (rst)
    !serr_n_o |-> sts_sig_serr); // R2

  AST_SELF_DETECT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_self_detect && !pw_tabort && !bctl_serr_fwd_en) |=> serr_n_o); // R6

  AST_NON_POSTED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_type != 2'b01 && !pw_tabort && !bctl_serr_fwd_en) |=> serr_n_o); // R8

  AST_SIGNALED_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst)
    $fell(sts_sig_serr) |-> $past(sts_clr_wr && sts_clr_data[0])); // R11
endmodule

bind bridge_serr_reporter bserr_checker u_bserr_checker (
  .clk              (clk),
  .rst              (rst),
  .cmd_serr_en      (cmd_serr_en),
  .bctl_serr_fwd_en (bctl_serr_fwd_en),
  .txn_valid        (txn_valid),
  .txn_type         (txn_type),
  .txn_self_detect  (txn_self_detect),
  .pw_tabort        (pw_tabort),
  .sts_clr_wr       (sts_clr_wr),
  .sts_clr_data     (sts_clr_data),
  .serr_n_o         (serr_n_o),
  .sts_sig_serr     (sts_sig_serr)
);

// File: tb/bridge_serr_reporter_test.sv
`timescale 1ns/1ps
module bridge_serr_reporter_test;
  logic clk = 1'b0;
  logic rst;
  logic cmd_serr_en, cmd_perr_resp, bctl_perr_resp, bctl_serr_fwd_en;
  logic pri_perr_seen, sec_perr_seen, txn_valid, txn_dir, txn_self_detect;
  logic [1:0] txn_type;
  logic sec_serr_n, pw_tabort, sts_clr_wr;
  logic [2:0] sts_clr_data;
  logic serr_n_o, sts_sig_serr, sts_rcv_serr, sts_pw_perr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bridge_serr_reporter uut (.*);

  // [10:9] type [8] dir [7] pri [6] sec [5] self [4] cmd_resp [3] bctl_resp
  // [2] serr_en [1] expected strobe [0] expected pw flag
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    11'b01_0_01_0_11_1_11, // R5 downstream, secondary only
    11'b01_0_10_0_11_1_00, // R5 downstream, primary only
    11'b01_1_10_0_11_1_11, // R5 upstream, primary only
    11'b01_1_01_0_11_1_00, // R5 upstream, secondary only
    11'b01_0_11_0_11_1_00, // R5 both buses
    11'b01_0_01_1_11_1_00, // R6 self detected
    11'b01_0_01_0_10_1_00, // R7 bridge-control response off
    11'b01_0_01_0_01_1_00, // R7 command response off
    11'b01_0_01_0_11_0_01, // R1 R12 master enable off
    11'b00_0_01_0_11_1_00, // R8 read downstream
    11'b00_1_10_0_11_1_00, // R8 read upstream
    11'b10_0_01_0_11_1_00, // R8 delayed write downstream
    11'b10_1_10_0_11_1_00, // R8 delayed write upstream
    11'b00_0_01_0_00_1_00, // R8 read, responses off
    11'b01_1_10_0_11_1_11  // R2 upstream again
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    txn_valid = 0; txn_type = 0; txn_dir = 0; txn_self_detect = 0;
    pri_perr_seen = 0; sec_perr_seen = 0; pw_tabort = 0;
    sts_clr_wr = 0; sts_clr_data = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); idle(); sts_clr_wr = 1; sts_clr_data = 3'b111;
    @(negedge clk); idle();
  endtask

  task automatic set_enables(input logic en, input logic fwd);
    cmd_serr_en = en; cmd_perr_resp = 1; bctl_perr_resp = 1; bctl_serr_fwd_en = fwd;
  endtask

  task automatic sec_event(input int hold, output int pulses);
    pulses = 0;
    @(negedge clk); sec_serr_n = 0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!serr_n_o) pulses++;
    end
    sec_serr_n = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!serr_n_o) pulses++;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p;
    rst = 1; sec_serr_n = 1; idle(); set_enables(1, 1);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("reset R10 strobe", serr_n_o, 1);
    chk("reset R11 flags", {sts_sig_serr, sts_rcv_serr, sts_pw_perr}, 0);

    for (int i = 0; i < NV; i++) begin
      clear_all();
      txn_valid = 1; txn_type = VEC[i][10:9]; txn_dir = VEC[i][8];
      pri_perr_seen = VEC[i][7]; sec_perr_seen = VEC[i][6];
      txn_self_detect = VEC[i][5]; cmd_perr_resp = VEC[i][4];
      bctl_perr_resp = VEC[i][3]; cmd_serr_en = VEC[i][2];
      @(negedge clk); idle();
      chk($sformatf("R5 R6 R7 R8 vec%0d strobe", i), serr_n_o, !VEC[i][1]);
      chk($sformatf("R2 vec%0d signaled", i), sts_sig_serr, VEC[i][1]);
      chk($sformatf("R12 vec%0d pw flag", i), sts_pw_perr, VEC[i][0]);
      set_enables(1, 1);
    end

    // R9 target abort, enabled then masked
    clear_all();
    pw_tabort = 1;
    @(negedge clk); idle();
    chk("R9 abort strobe", serr_n_o, 0);
    @(negedge clk);
    chk("R10 abort one clock", serr_n_o, 1);
    clear_all();
    cmd_serr_en = 0; pw_tabort = 1;
    @(negedge clk); idle();
    chk("R1 abort masked strobe", serr_n_o, 1);
    chk("R1 abort masked flag", sts_sig_serr, 0);
    set_enables(1, 1);

    // R10 simultaneous triggers merge
    clear_all();
    pw_tabort = 1; txn_valid = 1; txn_type = 2'b01; sec_perr_seen = 1;
    @(negedge clk); idle();
    chk("R10 merged low", serr_n_o, 0);
    @(negedge clk);
    chk("R10 merged single", serr_n_o, 1);

    // R3 R4 held secondary level
    clear_all();
    sec_event(30, p);
    chk("R3 held level one pulse", p, 1);
    chk("R4 received flag", sts_rcv_serr, 1);
    chk("R2 forwarded signaled", sts_sig_serr, 1);
    clear_all();
    set_enables(1, 0);
    sec_event(10, p);
    chk("R3 forward disabled pulses", p, 0);
    chk("R4 received without forward", sts_rcv_serr, 1);
    chk("R3 no signaled", sts_sig_serr, 0);
    clear_all();
    set_enables(0, 1);
    sec_event(10, p);
    chk("R1 forward masked pulses", p, 0);
    chk("R4 received masked", sts_rcv_serr, 1);
    set_enables(1, 1);

    // R11 set wins, per-bit clear, zero mask ignored
    clear_all();
    sec_event(5, p);
    @(negedge clk); sts_clr_wr = 1; sts_clr_data = 3'b000;
    @(negedge clk); idle();
    chk("R11 zero mask keeps sig", sts_sig_serr, 1);
    chk("R11 zero mask keeps rcv", sts_rcv_serr, 1);
    sts_clr_wr = 1; sts_clr_data = 3'b010;
    @(negedge clk); idle();
    chk("R11 bit1 cleared", sts_rcv_serr, 0);
    chk("R11 bit0 untouched", sts_sig_serr, 1);
    pw_tabort = 1; sts_clr_wr = 1; sts_clr_data = 3'b001;
    @(negedge clk); idle();
    chk("R11 set wins over clear", sts_sig_serr, 1);
    sts_clr_wr = 1; sts_clr_data = 3'b001;
    @(negedge clk); idle();
    chk("R11 clear takes effect", sts_sig_serr, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule